// File: doc/BRIEF.md
# Byte-Serial Two-Instruction Microsequenced Processor Core

This block is a multicycle processor core whose control unit steps through fixed microoperation sequences. One internal 16-bit bus connects the 16-bit program counter, instruction register, memory address register, accumulator and stack pointer, the 8-bit memory data register, and a 32-entry by 8-bit register file with a single port. Each microstep moves one value over the bus. The value can be the whole 16-bit word or one byte lane of it. Memory is one byte wide, so every 16-bit quantity moves as two bytes. Only the program counter, the accumulator and the stack pointer can count by themselves. Every other register changes only when the bus loads it.

Every instruction is fetched in six steps. The low byte of the instruction word comes from the lower address. The core then runs one of two execute sequences. The first is a pre-decrement indirect store. It lowers the pointer held in registers 27:26 by one, writes the new pointer back, and stores register r at that address. The second is an indirect call. It pushes the return address byte by byte, starting at the current stack pointer and moving to lower addresses, and then jumps to the pointer held in registers 31:30. Any other instruction word raises the error flag for one cycle, and fetching continues at the next word.

Memory is reached through a valid/ready request channel. While `mem_valid` is high, the core holds `mem_addr`, `mem_we` and `mem_wdata` steady, and a transfer completes in a cycle in which `mem_ready` is also high. `mem_valid` never depends on `mem_ready`. A memory that keeps `mem_ready` low stalls the current microstep for as long as it likes. For a read, `mem_rdata` must be valid in the cycle that `mem_ready` is high. `trace_step` shows the current microstep. The register file takes its contents at reset from a parameter.

Top module: `mseq_cpu`

## Requirements
- R1: While reset is high and in the cycle it is released, `trace_step` is 0, `mem_valid` is 0 and `err` is 0. The program counter resets to PC_RESET (default 0x0000) and the stack pointer to SP_RESET (default 0xFFFF).
- R2: With `mem_ready` held high, a fetch takes exactly 6 cycles. It reads the byte at PC, then the byte at PC+1, and treats the first byte as bits 7:0 of the instruction word. PC finishes 2 higher.
- R3: While `mem_valid` is high and `mem_ready` is low, the core keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` unchanged in the next cycle, and the microstep does not advance.
- R4: A word matching 1001 001r rrrr 1110 (r in bits 8:4) runs a 7-cycle execute phase. It computes X-1 as one 16-bit value, where X is register 27 (high byte) and register 26 (low byte), so a borrow crosses into the high byte. It then issues one byte write of register r to address X-1.
- R5: The decremented pointer is written back to registers 27:26, so each following store lands one address lower than the previous one.
- R6: The word 0x9509 runs an 8-cycle execute phase. Its first write puts the low byte of the return address (the address after the instruction) at SP. Its second write puts the high byte at SP-1.
- R7: After a call, SP is 2 lower, so the next call pushes its first byte at the address 2 below the previous call's first push.
- R8: After a call, the next fetch starts at the address formed by register 31 (high byte) and register 30 (low byte).
- R9: Any other word keeps `err` high for exactly one cycle (`trace_step` 31) and makes no memory write. The next cycle is step 0, and fetching resumes at the address after the word.
- R10: `trace_step` codes are 0 to 5 for the fetch steps, 8 to 14 for the store steps, 16 to 23 for the call steps and 31 for the error step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid while `mem_ready` is high on a read |
| trace_step | output | 5 | Current microstep code |
| err | output | 1 | Unknown instruction word seen |

## Verification
The hardest case to reach from the ports is a memory stall that falls inside a multi-byte sequence: between the two fetch reads, or between the two stack pushes of a call. In that case the held address and data must survive while the stack pointer and the program counter are half-way through their updates. The stimulus runs a random instruction stream placed at the call target, so each call loops back to it. During that stream `mem_ready` is dropped at random on about a third of the cycles, so stalls land on every memory step many times. A directed prologue with a ready memory first pins down the exact cycle counts, the pointer borrow from 0x4000 down to 0x3FFF, and the first push at the reset stack pointer.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RF_N   = 32;
  localparam int unsigned IDX_W  = $clog2(RF_N);
  localparam int unsigned STEP_W = 5;

  localparam logic [IDX_W-1:0] IDX_PL_LO = IDX_W'(26);
  localparam logic [IDX_W-1:0] IDX_PL_HI = IDX_W'(27);
  localparam logic [IDX_W-1:0] IDX_PT_LO = IDX_W'(30);
  localparam logic [IDX_W-1:0] IDX_PT_HI = IDX_W'(31);

  localparam logic [WORD_W-1:0] OPC_CALL_IND = 16'h9509;
  localparam logic [6:0]        OPC_STD_TOP  = 7'b1001001;
  localparam logic [3:0]        OPC_STD_BOT  = 4'b1110;

  typedef enum logic [STEP_W-1:0] {
    ST_F0 = 5'd0,  ST_F1 = 5'd1,  ST_F2 = 5'd2,  ST_F3 = 5'd3,
    ST_F4 = 5'd4,  ST_F5 = 5'd5,
    ST_S0 = 5'd8,  ST_S1 = 5'd9,  ST_S2 = 5'd10, ST_S3 = 5'd11,
    ST_S4 = 5'd12, ST_S5 = 5'd13, ST_S6 = 5'd14,
    ST_C0 = 5'd16, ST_C1 = 5'd17, ST_C2 = 5'd18, ST_C3 = 5'd19,
    ST_C4 = 5'd20, ST_C5 = 5'd21, ST_C6 = 5'd22, ST_C7 = 5'd23,
    ST_BAD = 5'd31
  } step_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_PC, BUS_AC, BUS_SP, BUS_MDR, BUS_RF
  } bus_e;

  typedef enum logic [2:0] {
    RS_PLO, RS_PHI, RS_TLO, RS_THI, RS_OPR
  } rsel_e;

  typedef enum logic [1:0] {OP_STD, OP_CALL, OP_BAD} opc_e;

  typedef struct packed {
    bus_e  src;
    logic  hi_lane;
    logic  ld_mar;
    logic  ld_mdr;
    logic  ld_ir_lo;
    logic  ld_ir_hi;
    logic  ld_ac_lo;
    logic  ld_ac_hi;
    logic  ld_pc_lo;
    logic  ld_pc_hi;
    logic  rf_we;
    rsel_e rsel;
    logic  ac_dec;
    logic  pc_inc;
    logic  sp_dec;
    logic  mem_rd;
    logic  mem_wr;
  } uop_t;

  function automatic opc_e classify(input logic [WORD_W-1:0] w);
    if (w[15:9] == OPC_STD_TOP && w[3:0] == OPC_STD_BOT) return OP_STD;
    else if (w == OPC_CALL_IND) return OP_CALL;
    else return OP_BAD;
  endfunction

  function automatic uop_t uop_of(input step_e s);
    uop_t u;
    u = '0;
    case (s)
      ST_F0: begin u.src = BUS_PC;  u.ld_mar = 1'b1; end
      ST_F1: begin u.mem_rd = 1'b1; u.pc_inc = 1'b1; end
      ST_F2: begin u.src = BUS_MDR; u.ld_ir_lo = 1'b1; end
      ST_F3: begin u.src = BUS_PC;  u.ld_mar = 1'b1; end
      ST_F4: begin u.mem_rd = 1'b1; u.pc_inc = 1'b1; end
      ST_F5: begin u.src = BUS_MDR; u.ld_ir_hi = 1'b1; end
      ST_S0: begin u.src = BUS_RF; u.rsel = RS_PLO; u.ld_ac_lo = 1'b1; end
      ST_S1: begin u.src = BUS_RF; u.rsel = RS_PHI; u.ld_ac_hi = 1'b1; end
      ST_S2: begin u.ac_dec = 1'b1; end
      ST_S3: begin u.src = BUS_AC; u.ld_mar = 1'b1; u.rf_we = 1'b1; u.rsel = RS_PLO; end
      ST_S4: begin u.src = BUS_AC; u.hi_lane = 1'b1; u.rf_we = 1'b1; u.rsel = RS_PHI; end
      ST_S5: begin u.src = BUS_RF; u.rsel = RS_OPR; u.ld_mdr = 1'b1; end
      ST_S6: begin u.mem_wr = 1'b1; end
      ST_C0: begin u.src = BUS_SP; u.ld_mar = 1'b1; end
      ST_C1: begin u.src = BUS_PC; u.ld_mdr = 1'b1; end
      ST_C2: begin u.mem_wr = 1'b1; u.sp_dec = 1'b1; end
      ST_C3: begin u.src = BUS_SP; u.ld_mar = 1'b1; end
      ST_C4: begin u.src = BUS_PC; u.hi_lane = 1'b1; u.ld_mdr = 1'b1; end
      ST_C5: begin u.mem_wr = 1'b1; u.sp_dec = 1'b1; end
      ST_C6: begin u.src = BUS_RF; u.rsel = RS_TLO; u.ld_pc_lo = 1'b1; end
      ST_C7: begin u.src = BUS_RF; u.rsel = RS_THI; u.ld_pc_hi = 1'b1; end
      default: u = '0;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/mseq_rf.sv
module mseq_rf
  import mseq_pkg::*;
#(
  parameter int unsigned DEPTH = RF_N,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter logic [DEPTH*BYTE_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     idx,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) regs[i] <= INIT[i*BYTE_W +: BYTE_W];
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = regs[idx];
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] ir_lo,
  input  logic [BYTE_W-1:0] mdr,
  output step_e             step,
  output uop_t              u,
  output logic              fire
);
  step_e nxt;
  logic  mem_op;

  always_comb begin
    u      = uop_of(step);
    mem_op = u.mem_rd | u.mem_wr;
    fire   = !mem_op || mem_ready;
  end

  always_comb begin
    nxt = step;
    if (fire) begin
      case (step)
        ST_F5: begin
          case (classify({mdr, ir_lo}))
            OP_STD:  nxt = ST_S0;
            OP_CALL: nxt = ST_C0;
            default: nxt = ST_BAD;
          endcase
        end
        ST_S6, ST_C7, ST_BAD: nxt = ST_F0;
        default: nxt = step_e'(step + STEP_W'(1));
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_F0;
    else     step <= nxt;
  end

  AST_EXEC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F5) |=> (step == ST_S0 || step == ST_C0 || step == ST_BAD)); // R10
endmodule

// File: rtl/mseq_dp.sv
module mseq_dp
  import mseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] PC_RESET = '0,
  parameter logic [WORD_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  uop_t              u,
  input  logic              fire,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [IDX_W-1:0]  rf_idx,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic [WORD_W-1:0] mar,
  output logic [BYTE_W-1:0] mdr,
  output logic [WORD_W-1:0] ir
);
  logic [WORD_W-1:0] pc, ac, sp, bus;
  logic [BYTE_W-1:0] lane;

  always_comb begin
    case (u.src)
      BUS_PC:  bus = pc;
      BUS_AC:  bus = ac;
      BUS_SP:  bus = sp;
      BUS_MDR: bus = {mdr, mdr};
      BUS_RF:  bus = {rf_rdata, rf_rdata};
      default: bus = '0;
    endcase
    lane = u.hi_lane ? bus[WORD_W-1:BYTE_W] : bus[BYTE_W-1:0];
  end

  always_comb begin
    case (u.rsel)
      RS_PLO:  rf_idx = IDX_PL_LO;
      RS_PHI:  rf_idx = IDX_PL_HI;
      RS_TLO:  rf_idx = IDX_PT_LO;
      RS_THI:  rf_idx = IDX_PT_HI;
      default: rf_idx = ir[4 +: IDX_W];
    endcase
  end

  assign rf_we    = u.rf_we & fire;
  assign rf_wdata = lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= PC_RESET;
      sp  <= SP_RESET;
      ac  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else if (fire) begin
      if (u.ld_mar) mar <= bus;
      if (u.mem_rd)      mdr <= mem_rdata;
      else if (u.ld_mdr) mdr <= lane;
      if (u.ld_ir_lo) ir[BYTE_W-1:0]      <= lane;
      if (u.ld_ir_hi) ir[WORD_W-1:BYTE_W] <= lane;
      if (u.ac_dec) ac <= ac - WORD_W'(1);
      else begin
        if (u.ld_ac_lo) ac[BYTE_W-1:0]      <= lane;
        if (u.ld_ac_hi) ac[WORD_W-1:BYTE_W] <= lane;
      end
      if (u.pc_inc) pc <= pc + WORD_W'(1);
      else begin
        if (u.ld_pc_lo) pc[BYTE_W-1:0]      <= lane;
        if (u.ld_pc_hi) pc[WORD_W-1:BYTE_W] <= lane;
      end
      if (u.sp_dec) sp <= sp - WORD_W'(1);
    end
  end

  // Shadow captures used only by the properties below.
  logic [WORD_W-1:0] cap_pc, cap_ptr, cap_push, cap_tgt;
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_pc <= '0; cap_ptr <= '0; cap_push <= '0; cap_tgt <= '0;
    end else begin
      if (step == ST_F0) cap_pc <= pc;
      if (step == ST_S0) cap_ptr[BYTE_W-1:0]      <= rf_rdata;
      if (step == ST_S1) cap_ptr[WORD_W-1:BYTE_W] <= rf_rdata;
      if (step == ST_C2 && fire) cap_push <= mar;
      if (step == ST_C6) cap_tgt[BYTE_W-1:0]      <= rf_rdata;
      if (step == ST_C7) cap_tgt[WORD_W-1:BYTE_W] <= rf_rdata;
    end
  end

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F5) |-> (pc == cap_pc + WORD_W'(2))); // R2
  AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S6) |-> (mar == cap_ptr - WORD_W'(1))); // R4
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (step == ST_C5) |-> (mar == cap_push - WORD_W'(1) && mdr == pc[WORD_W-1:BYTE_W])); // R6
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
    (step == ST_C7) |=> (pc == cap_tgt)); // R8
endmodule

// File: rtl/mseq_cpu.sv
module mseq_cpu
  import mseq_pkg::*;
#(
  parameter logic [WORD_W-1:0]      PC_RESET = 16'h0000,
  parameter logic [WORD_W-1:0]      SP_RESET = 16'hFFFF,
  parameter logic [RF_N*BYTE_W-1:0] RF_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [STEP_W-1:0] trace_step,
  output logic              err
);
  step_e             step;
  uop_t              u;
  logic              fire;
  logic [IDX_W-1:0]  rf_idx;
  logic              rf_we;
  logic [BYTE_W-1:0] rf_wdata, rf_rdata;
  logic [WORD_W-1:0] mar, ir;
  logic [BYTE_W-1:0] mdr;

  mseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mem_ready(mem_ready),
    .ir_lo(ir[BYTE_W-1:0]), .mdr(mdr),
    .step(step), .u(u), .fire(fire)
  );

  mseq_dp #(.PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_dp (
    .clk(clk), .rst(rst), .step(step), .u(u), .fire(fire),
    .mem_rdata(mem_rdata), .rf_rdata(rf_rdata),
    .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mar(mar), .mdr(mdr), .ir(ir)
  );

  mseq_rf #(.DEPTH(RF_N), .INIT(RF_RESET)) u_rf (
    .clk(clk), .rst(rst), .idx(rf_idx), .we(rf_we),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );

  assign mem_valid  = u.mem_rd | u.mem_wr;
  assign mem_we     = u.mem_wr;
  assign mem_addr   = mar;
  assign mem_wdata  = mdr;
  assign trace_step = step;
  assign err        = (step == ST_BAD);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata))); // R3
  AST_BAD_REFETCH: assert property (@(posedge clk) disable iff (rst)
    err |=> (trace_step == STEP_W'(0) && !mem_valid && !err)); // R9
endmodule

// File: tb/sim_mseq_cpu.sv
module sim_mseq_cpu;
  localparam int N_INSTR  = 180;
  localparam int WATCHDOG = 150000;
  localparam logic [15:0] TGT = 16'h0200;

  function automatic logic [255:0] mk_rf();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'((i * 37 + 11) & 255);
    v[26*8 +: 8] = 8'h00; v[27*8 +: 8] = 8'h40;
    v[30*8 +: 8] = TGT[7:0]; v[31*8 +: 8] = TGT[15:8];
    v[14*8 +: 8] = 8'hA5;
    return v;
  endfunction
  localparam logic [255:0] RF_INIT = mk_rf();

  logic clk = 1'b0, rst = 1'b1, mem_ready = 1'b1;
  logic mem_valid, mem_we, err;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  trace_step;
  logic [7:0]  mem [logic [15:0]];

  always #4 clk = ~clk;

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  assign mem_rdata = rd_byte(mem_addr);

  mseq_cpu #(.RF_RESET(RF_INIT)) u0 (
    .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .trace_step(trace_step), .err(err)
  );

  typedef struct { logic we; logic [15:0] addr; logic [7:0] data; string tag; } txn_t;
  txn_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_pc = 16'h0000, m_sp = 16'hFFFF, m_x;
  logic [7:0]  m_rf [32];
  int prev_kind = 0, st_cnt = 0, call_cnt = 0, bad_exp = 0, err_seen = 0;
  int f0_cnt = 0, cyc = 0;
  int f0_time [5];
  bit stall_pend = 0;
  logic [15:0] s_addr; logic s_we; logic [7:0] s_wd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_std(input logic [15:0] w);
    return (w[15:9] == 7'b1001001) && (w[3:0] == 4'b1110);
  endfunction

  task automatic put(input logic we, input logic [15:0] a, input logic [7:0] d, input string t);
    txn_t e; e.we = we; e.addr = a; e.data = d; e.tag = t; q.push_back(e);
  endtask

  task automatic model_step();
    logic [15:0] w; string ft; int r;
    w  = {rd_byte(m_pc + 16'd1), rd_byte(m_pc)};
    ft = (prev_kind == 1) ? "R8" : (prev_kind == 2) ? "R9" : "R2";
    put(1'b0, m_pc, rd_byte(m_pc), ft);
    put(1'b0, m_pc + 16'd1, rd_byte(m_pc + 16'd1), ft);
    m_pc = m_pc + 16'd2;
    if (is_std(w)) begin
      m_x = {m_rf[27], m_rf[26]} - 16'd1;
      m_rf[26] = m_x[7:0]; m_rf[27] = m_x[15:8];
      r = int'(w[8:4]);
      put(1'b1, m_x, m_rf[r], (st_cnt == 0) ? "R4" : "R5");
      st_cnt++; prev_kind = 0;
    end else if (w == 16'h9509) begin
      put(1'b1, m_sp, m_pc[7:0], (call_cnt == 0) ? "R6" : "R7");
      put(1'b1, m_sp - 16'd1, m_pc[15:8], (call_cnt == 0) ? "R6" : "R7");
      m_sp = m_sp - 16'd2;
      m_pc = {m_rf[31], m_rf[30]};
      call_cnt++; prev_kind = 1;
    end else begin
      bad_exp++; prev_kind = 2;
    end
  endtask

  task automatic put_word(input logic [15:0] a, input logic [15:0] w);
    mem[a] = w[7:0]; mem[a + 16'd1] = w[15:8];
  endtask

  task automatic build_program();
    logic [15:0] w; int k, r;
    put_word(16'h0000, 16'h92EE);   // store r14 via pre-decremented pointer
    put_word(16'h0002, 16'h923E);   // store r3
    put_word(16'h0004, 16'hFFFF);   // unknown word
    put_word(16'h0006, 16'h9509);   // indirect call
    for (int i = 0; i < 23; i++) begin
      k = int'($urandom % 8);
      if (k < 4) begin
        do r = int'($urandom % 32); while (r == 26 || r == 27);
        w = {7'b1001001, 5'(r), 4'b1110};
      end else if (k < 6) begin
        do w = 16'($urandom); while (is_std(w) || w == 16'h9509);
      end else w = 16'h92EE;
      put_word(TGT + 16'(2 * i), w);
    end
    put_word(TGT + 16'd46, 16'h9509);
  endtask

  task automatic cycle_step();
    txn_t e; int k;
    if (stall_pend)
      chk(mem_valid && mem_addr == s_addr && mem_we == s_we && mem_wdata == s_wd,
          "R3", "request held during stall", {mem_valid, mem_we, mem_addr}, {1'b1, s_we, s_addr});
    stall_pend = 0;
    if (err) err_seen++;
    if (trace_step == 5'd0) begin
      if (f0_cnt < 5) f0_time[f0_cnt] = cyc;
      f0_cnt++;
    end
    if (f0_cnt == 1) begin                       // R10: step codes of the first store
      k = cyc - f0_time[0];
      if (k < 13) chk(int'(trace_step) == ((k < 6) ? k : k + 2), "R10", "trace code",
                      32'(trace_step), 32'((k < 6) ? k : k + 2));
    end
    mem_ready = (f0_cnt <= 4) ? 1'b1 : (($urandom % 10) < 7);
    if (mem_valid && mem_ready) begin
      if (q.size() == 0) model_step();
      e = q.pop_front();
      chk(mem_we == e.we && mem_addr == e.addr, e.tag, "access kind/address",
          {15'd0, mem_we, mem_addr}, {15'd0, e.we, e.addr});
      if (e.we) chk(mem_wdata == e.data, e.tag, "write data", 32'(mem_wdata), 32'(e.data));
    end
    if (mem_valid && !mem_ready) begin
      stall_pend = 1; s_addr = mem_addr; s_we = mem_we; s_wd = mem_wdata;
    end
    cyc++;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 32; i++) m_rf[i] = RF_INIT[i*8 +: 8];
    build_program();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(trace_step == 5'd0 && !mem_valid && !err, "R1", "reset state",
        {mem_valid, err, trace_step}, 32'd0);
    rst = 1'b0;
    while (f0_cnt <= N_INSTR && cyc < WATCHDOG) begin
      cycle_step();
      @(negedge clk);
    end
    if (cyc >= WATCHDOG) chk(1'b0, "WD", "watchdog expired", cyc, WATCHDOG);
    chk(f0_time[1] - f0_time[0] == 13, "R4", "fetch+store cycles", f0_time[1] - f0_time[0], 13);
    chk(f0_time[2] - f0_time[1] == 13, "R5", "second store cycles", f0_time[2] - f0_time[1], 13);
    chk(f0_time[3] - f0_time[2] == 7,  "R9", "unknown word cycles", f0_time[3] - f0_time[2], 7);
    chk(f0_time[4] - f0_time[3] == 14, "R6", "fetch+call cycles", f0_time[4] - f0_time[3], 14);
    chk(q.size() == 0, "R2", "pending accesses", q.size(), 0);
    chk(err_seen == bad_exp, "R9", "error pulses", err_seen, bad_exp);
    chk(call_cnt > 1 && st_cnt > 2, "R7", "stream coverage", call_cnt, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule